// File: doc/BRIEF.md
# Command Packet Register-Write Sequencer

This block takes one command packet at a time as a byte stream with a valid/ready handshake. It first collects a 16-byte header. Byte 2 of the header holds the control flags, byte 3 the packet length, and bytes 8 to 11 the scatter-gather pointer. After the header the block walks a list of value/address byte pairs. For each pair it issues a single-cycle write on a device register port, unless the pair is marked to be skipped. The last pair in the list is marked by a flag.

When the list ends, the pointer goes to a data engine if the packet carries a data phase, and the block waits for that engine to finish. It then writes a one-byte completion code back and raises an interrupt if the packet asked for one. Every packet is consumed to its declared length, including malformed ones, so the stream stays aligned for the next packet. A packet that is not marked valid, or whose list never ends, completes with a packet-error code and no handoff.

Top module: `cps_top`

## Requirements
- R1: After reset, `busy`, `in_ready`, `reg_we`, `sg_valid`, `resp_we` and `irq` are low. A `go` pulse while idle starts a packet and raises `busy` on the next cycle.
- R2: The block accepts exactly 16 + 8·L stream bytes per packet, where L is header byte 3. It holds `in_ready` low outside a packet.
- R3: The list starts at byte 16 and is made of pairs: first the value, then the address byte. Each pair whose address byte has bit 5 clear produces one `reg_we` pulse in the cycle after the address byte is accepted. The pulses keep list order. `reg_wdata` is the value, and `reg_addr` is the address byte with bits 7 and 5 forced to zero.
- R4: A pair whose address byte has bit 5 set produces no write.
- R5: Bit 7 of an address byte marks the last pair. That pair is still written unless bit 5 is also set. Any bytes after it, up to the declared length, are consumed without writes.
- R6: If the packet is valid, its list ends normally and control bit 2 (data phase) is set, `sg_valid` pulses for one cycle. At that pulse `sg_ptr` equals header bytes 8–11 read little-endian. The completion waits for `xfer_done`.
- R7: A valid packet whose list ends completes with a single-cycle `resp_we`. `resp_data` is 0x01, or 0x09 when `dev_err` is high at completion.
- R8: A packet with control bit 0 (valid) clear produces no writes and no pointer handoff, and completes with 0x02.
- R9: A valid packet whose declared list runs out without an end flag completes with 0x02 and no handoff. This includes L = 0.
- R10: `irq` pulses together with `resp_we` exactly when control bit 3 is set.
- R11: A `go` pulse while busy is ignored, and `busy` falls in the cycle after `resp_we`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start one packet |
| busy | output | 1 | Packet in progress |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block accepts the byte |
| reg_we | output | 1 | Device register write strobe |
| reg_addr | output | 8 | Device register address |
| reg_wdata | output | 8 | Device register data |
| sg_valid | output | 1 | Pointer handoff pulse |
| sg_ptr | output | 32 | Scatter-gather list pointer |
| xfer_done | input | 1 | Data engine finished |
| dev_err | input | 1 | Device reports an error |
| resp_we | output | 1 | Completion byte write strobe |
| resp_data | output | 8 | Completion byte |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest case to reach from the ports is a list that ends early, followed by trailing bytes that look like real register pairs. If the sequencer mishandled the drain phase, it would write them or lose stream alignment. Directed packets place the end flag partway through a longer declared length and fill the rest with non-skip pairs. Randomly generated packets also move the end position, drop it entirely, clear the valid bit, and insert idle gaps in the stream. A stray `go` is injected in the middle of one packet to show it is ignored.

// File: rtl/cps_pkg.sv
package cps_pkg;

  localparam int HDR_BYTES = 16;

  // control byte flag positions
  localparam int CTL_VALID = 0;
  localparam int CTL_DATA  = 2;
  localparam int CTL_IRQ   = 3;

  // address byte flag positions
  localparam int AF_SKIP = 5;
  localparam int AF_END  = 7;

  localparam logic [7:0] RSP_DONE   = 8'h01;
  localparam logic [7:0] RSP_PKTERR = 8'h02;
  localparam logic [7:0] RSP_DEVERR = 8'h08;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_LIST, S_DRAIN, S_FIN, S_SG, S_WAIT, S_RESP
  } cps_state_e;

  // device address: flag bits removed
  function automatic logic [7:0] dev_addr(input logic [7:0] a);
    logic [7:0] r;
    r = a;
    r[AF_SKIP] = 1'b0;
    r[AF_END]  = 1'b0;
    return r;
  endfunction

  // completion code for a packet whose list ended properly
  function automatic logic [7:0] ok_code(input logic derr);
    return derr ? (RSP_DONE | RSP_DEVERR) : RSP_DONE;
  endfunction

endpackage

// File: rtl/cps_hdr.sv
module cps_hdr
  import cps_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic [3:0]       idx,
  input  logic [7:0]       din,
  output logic             ctl_valid,
  output logic             ctl_data,
  output logic             ctl_irq,
  output logic [LEN_W-1:0] len,
  output logic [PTR_W-1:0] sg_ptr
);
  localparam int PB = PTR_W / 8;
  localparam int SG_BASE = 8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_valid <= 1'b0;
      ctl_data  <= 1'b0;
      ctl_irq   <= 1'b0;
      len       <= '0;
    end else if (cap) begin
      if (idx == 4'd2) begin
        ctl_valid <= din[CTL_VALID];
        ctl_data  <= din[CTL_DATA];
        ctl_irq   <= din[CTL_IRQ];
      end
      if (idx == 4'd3) len <= din[LEN_W-1:0];
    end
  end

  // one lane per pointer byte, little-endian
  for (genvar b = 0; b < PB; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sg_ptr[8*b +: 8] <= '0;
      else if (cap && idx == 4'(SG_BASE + b)) sg_ptr[8*b +: 8] <= din;
    end
  end

endmodule

// File: rtl/cps_regwr.sv
module cps_regwr
  import cps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       acc,
  input  logic [7:0] din,
  output logic       end_hit,
  output logic       reg_we,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata
);
  logic       odd;
  logic [7:0] val_q;

  assign end_hit = acc && odd && din[AF_END];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odd       <= 1'b0;
      val_q     <= '0;
      reg_we    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (clr) begin
        odd <= 1'b0;
      end else if (acc) begin
        odd <= !odd;
        if (!odd) begin
          val_q <= din;
        end else begin
          reg_we    <= !din[AF_SKIP];
          reg_addr  <= dev_addr(din);
          reg_wdata <= val_q;
        end
      end
    end
  end

endmodule

// File: rtl/cps_fsm.sv
module cps_fsm
  import cps_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             in_valid,
  input  logic             ctl_valid,
  input  logic             ctl_data,
  input  logic [LEN_W-1:0] len,
  input  logic             end_hit,
  input  logic             xfer_done,
  input  logic             dev_err,
  output logic             in_ready,
  output logic             busy,
  output logic             hdr_cap,
  output logic [3:0]       hdr_idx,
  output logic             list_acc,
  output logic             list_clr,
  output logic             sg_valid,
  output logic             resp_we,
  output logic [7:0]       resp_data
);
  localparam int REM_W = LEN_W + 3;
  localparam logic [REM_W-1:0] HDR_LAST = REM_W'(HDR_BYTES - 1);
  localparam logic [REM_W-1:0] ONE      = REM_W'(1);

  cps_state_e       state;
  logic [REM_W-1:0] cnt;
  logic             err;
  logic             acc;

  assign in_ready = (state == S_HDR) || (state == S_LIST) || (state == S_DRAIN);
  assign acc      = in_valid && in_ready;
  assign busy     = (state != S_IDLE);
  assign hdr_cap  = acc && (state == S_HDR);
  assign hdr_idx  = cnt[3:0];
  assign list_acc = acc && (state == S_LIST);
  assign list_clr = (state == S_HDR);
  assign sg_valid = (state == S_SG);
  assign resp_we  = (state == S_RESP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      err       <= 1'b0;
      resp_data <= '0;
    end else begin
      case (state)
        S_IDLE: if (go) begin
          state <= S_HDR;
          cnt   <= '0;
          err   <= 1'b0;
        end
        S_HDR: if (acc) begin
          if (cnt == HDR_LAST) begin
            if (len == '0) begin
              err   <= 1'b1;
              state <= S_FIN;
            end else begin
              cnt   <= {len, 3'b000};
              err   <= !ctl_valid;
              state <= ctl_valid ? S_LIST : S_DRAIN;
            end
          end else begin
            cnt <= cnt + ONE;
          end
        end
        S_LIST: if (acc) begin
          cnt <= cnt - ONE;
          if (cnt == ONE) begin
            state <= S_FIN;
            if (!end_hit) err <= 1'b1;
          end else if (end_hit) begin
            state <= S_DRAIN;
          end
        end
        S_DRAIN: if (acc) begin
          cnt <= cnt - ONE;
          if (cnt == ONE) state <= S_FIN;
        end
        S_FIN: begin
          if (err) begin
            resp_data <= RSP_PKTERR;
            state     <= S_RESP;
          end else if (ctl_data) begin
            state <= S_SG;
          end else begin
            resp_data <= ok_code(dev_err);
            state     <= S_RESP;
          end
        end
        S_SG: state <= S_WAIT;
        S_WAIT: if (xfer_done) begin
          resp_data <= ok_code(dev_err);
          state     <= S_RESP;
        end
        S_RESP: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cps_top.sv
module cps_top
  import cps_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic             busy,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             reg_we,
  output logic [7:0]       reg_addr,
  output logic [7:0]       reg_wdata,
  output logic             sg_valid,
  output logic [PTR_W-1:0] sg_ptr,
  input  logic             xfer_done,
  input  logic             dev_err,
  output logic             resp_we,
  output logic [7:0]       resp_data,
  output logic             irq
);
  logic             ctl_valid, ctl_data, ctl_irq;
  logic [LEN_W-1:0] len;
  logic             hdr_cap, list_acc, list_clr, end_hit;
  logic [3:0]       hdr_idx;

  cps_hdr #(.PTR_W(PTR_W), .LEN_W(LEN_W)) u_hdr (
    .clk(clk), .rst_n(rst_n), .cap(hdr_cap), .idx(hdr_idx), .din(in_data),
    .ctl_valid(ctl_valid), .ctl_data(ctl_data), .ctl_irq(ctl_irq),
    .len(len), .sg_ptr(sg_ptr)
  );

  cps_regwr u_wr (
    .clk(clk), .rst_n(rst_n), .clr(list_clr), .acc(list_acc), .din(in_data),
    .end_hit(end_hit), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
  );

  cps_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .go(go), .in_valid(in_valid),
    .ctl_valid(ctl_valid), .ctl_data(ctl_data), .len(len), .end_hit(end_hit),
    .xfer_done(xfer_done), .dev_err(dev_err),
    .in_ready(in_ready), .busy(busy), .hdr_cap(hdr_cap), .hdr_idx(hdr_idx),
    .list_acc(list_acc), .list_clr(list_clr), .sg_valid(sg_valid),
    .resp_we(resp_we), .resp_data(resp_data)
  );

  assign irq = resp_we && ctl_irq;

endmodule

// File: rtl/cps_chk.sv
module cps_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       go,
  input logic       busy,
  input logic       in_ready,
  input logic       reg_we,
  input logic [7:0] reg_addr,
  input logic       sg_valid,
  input logic       resp_we,
  input logic [7:0] resp_data,
  input logic       irq
);
  // R2
  ready_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);

  // R3
  addr_flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (reg_addr[7] == 1'b0 && reg_addr[5] == 1'b0));

  // R6
  sg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sg_valid |=> !sg_valid);

  // R7
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_we |=> !resp_we);

  // R7
  resp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_we |-> !(resp_data[0] && resp_data[1]));

  // R5
  no_write_at_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_we |-> !reg_we);

  // R10
  irq_with_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> resp_we);

  // R11
  idle_after_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_we |=> !busy);

  // R1
  start_by_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go));
endmodule

bind cps_top cps_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .in_ready(in_ready),
  .reg_we(reg_we), .reg_addr(reg_addr), .sg_valid(sg_valid),
  .resp_we(resp_we), .resp_data(resp_data), .irq(irq)
);

// File: tb/tb_cps_top.sv
module tb_cps_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic xfer_done = 1'b0, dev_err = 1'b0;
  logic busy, in_ready, reg_we, sg_valid, resp_we, irq;
  logic [7:0] reg_addr, reg_wdata, resp_data;
  logic [31:0] sg_ptr;

  cps_top dut (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sg_valid(sg_valid), .sg_ptr(sg_ptr),
    .xfer_done(xfer_done), .dev_err(dev_err), .resp_we(resp_we),
    .resp_data(resp_data), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] pk[$];
  logic [7:0] vals[64], adrs[64];
  logic [7:0] got_a[$], got_d[$], exp_a[$], exp_d[$];
  int acc_cnt, sg_cnt, resp_cnt, xd_cnt, xd_cyc, resp_cyc;
  logic [31:0] sg_got;
  logic [7:0] resp_got;
  logic irq_got;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  // monitor and data-engine responder
  always @(negedge clk) begin
    if (in_valid && in_ready) acc_cnt++;
    if (reg_we) begin got_a.push_back(reg_addr); got_d.push_back(reg_wdata); end
    if (resp_we) begin resp_cnt++; resp_got = resp_data; irq_got = irq; resp_cyc = cyc; end
    if (xd_cnt > 0) begin
      xd_cnt--;
      if (xd_cnt == 0) begin xfer_done = 1'b1; xd_cyc = cyc; end
    end else xfer_done = 1'b0;
    if (sg_valid) begin sg_cnt++; sg_got = sg_ptr; xd_cnt = 1 + int'($urandom % 4); end
  end

  // build a packet: header, npairs pairs, zero pad / truncate to 16+8*len
  task automatic assemble(input logic [7:0] ctrl, input logic [7:0] len,
                          input int npairs, input logic [31:0] sgp);
    pk.delete();
    pk.push_back(8'h00); pk.push_back(8'h00); pk.push_back(ctrl); pk.push_back(len);
    for (int i = 0; i < 4; i++) pk.push_back(8'($urandom));
    for (int i = 0; i < 4; i++) pk.push_back(sgp[8*i +: 8]);
    for (int i = 0; i < 4; i++) pk.push_back(8'h00);
    for (int i = 0; i < npairs; i++) begin pk.push_back(vals[i]); pk.push_back(adrs[i]); end
    while (pk.size() < 16 + 8 * int'(len)) pk.push_back(8'h00);
    while (pk.size() > 16 + 8 * int'(len)) void'(pk.pop_back());
  endtask

  // reference: expected writes and whether the list ended properly
  function automatic bit model();
    bit ended = 0;
    exp_a.delete(); exp_d.delete();
    if (!pk[2][0]) return 0;
    for (int i = 16; i + 1 < pk.size(); i += 2) begin
      if (!pk[i+1][5]) begin
        exp_a.push_back({1'b0, pk[i+1][6], 1'b0, pk[i+1][4:0]});
        exp_d.push_back(pk[i]);
      end
      if (pk[i+1][7]) begin ended = 1; break; end
    end
    if (!ended) begin exp_a.delete(); exp_d.delete(); end
    return ended;
  endfunction

  task automatic run_pkt(input bit derr, input int maxgap, input bit go_mid,
                         input string wtag, input string rtag);
    bit ok;
    int t;
    logic [7:0] er;
    ok = model();
    // a list without end still writes pairs it saw; recompute those for the write check
    if (pk[2][0] && !ok) begin
      for (int i = 16; i + 1 < pk.size(); i += 2)
        if (!pk[i+1][5]) begin
          exp_a.push_back({1'b0, pk[i+1][6], 1'b0, pk[i+1][4:0]});
          exp_d.push_back(pk[i]);
        end
    end
    got_a.delete(); got_d.delete();
    acc_cnt = 0; sg_cnt = 0; resp_cnt = 0; xd_cyc = 0; resp_cyc = 0;
    dev_err = derr;
    @(posedge clk); #2 go = 1'b1;
    @(posedge clk); #2 go = 1'b0;
    for (int i = 0; i < pk.size(); i++) begin
      int gap = (maxgap > 0) ? int'($urandom % (maxgap + 1)) : 0;
      if (gap > 0) begin
        in_valid = 1'b0;
        repeat (gap) begin @(posedge clk); #2; end
      end
      in_valid = 1'b1; in_data = pk[i];
      go = (go_mid && i == 5);
      t = 0;
      forever begin
        @(negedge clk);
        if (in_ready) break;
        t++;
        if (t > 200) break;
      end
      @(posedge clk); #2;
      go = 1'b0;
    end
    in_valid = 1'b0;
    t = 0;
    while (resp_cnt == 0 && t < 300) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    er = !ok ? 8'h02 : (derr ? 8'h09 : 8'h01);
    chk(acc_cnt == pk.size(), "R2", acc_cnt, pk.size());
    chk(!in_ready, "R2", in_ready, 0);
    chk(got_a.size() == exp_a.size(), wtag, got_a.size(), exp_a.size());
    for (int i = 0; i < exp_a.size() && i < got_a.size(); i++) begin
      chk(got_a[i] == exp_a[i], wtag, got_a[i], exp_a[i]);
      chk(got_d[i] == exp_d[i], wtag, got_d[i], exp_d[i]);
    end
    chk(sg_cnt == ((ok && pk[2][2]) ? 1 : 0), "R6", sg_cnt, (ok && pk[2][2]));
    if (ok && pk[2][2]) begin
      chk(sg_got == {pk[11], pk[10], pk[9], pk[8]}, "R6", sg_got, {pk[11], pk[10], pk[9], pk[8]});
      chk(resp_cyc > xd_cyc, "R6", resp_cyc, xd_cyc + 1);
    end
    chk(resp_cnt == 1, rtag, resp_cnt, 1);
    chk(resp_got == er, rtag, resp_got, er);
    chk(irq_got == pk[2][3], "R10", irq_got, pk[2][3]);
    chk(!busy, "R11", busy, 0);
  endtask

  task automatic std_list();
    vals[0] = 8'hE0; adrs[0] = 8'h16;
    vals[1] = 8'h08; adrs[1] = 8'h12;
    vals[2] = 8'h11; adrs[2] = 8'h13;
    vals[3] = 8'h22; adrs[3] = 8'h14;
    vals[4] = 8'h33; adrs[4] = 8'h15;
    vals[5] = 8'h00; adrs[5] = 8'h0E;
    vals[6] = 8'h5A; adrs[6] = 8'h2E;   // skipped
    vals[7] = 8'hC8; adrs[7] = 8'h97;   // command, last
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    // R1: reset state
    chk(!busy && !in_ready && !reg_we && !sg_valid && !resp_we && !irq, "R1",
        {busy, in_ready, reg_we, sg_valid, resp_we, irq}, 0);
    #2 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    chk(!busy && !in_ready, "R1", {busy, in_ready}, 0);

    // R3 R4 R6 R10: eight-pair list with data phase and interrupt
    std_list();
    assemble(8'h0D, 8'd2, 8, 32'h1234_5678);
    run_pkt(0, 0, 0, "R3", "R7");

    // R3 R7: longer list, no data, no irq
    std_list();
    for (int i = 11; i >= 4; i--) begin vals[i] = vals[i-4]; adrs[i] = adrs[i-4]; end
    vals[1] = 8'h01; adrs[1] = 8'h12; vals[2] = 8'h02; adrs[2] = 8'h13;
    vals[3] = 8'h03; adrs[3] = 8'h14; vals[4] = 8'h04; adrs[4] = 8'h15;
    assemble(8'h01, 8'd3, 12, 32'h0);
    run_pkt(0, 2, 0, "R4", "R7");

    // R7: device error with data phase
    std_list();
    assemble(8'h05, 8'd2, 8, 32'hCAFE_0010);
    run_pkt(1, 1, 0, "R3", "R7");

    // R8: valid bit clear
    std_list();
    assemble(8'h0C, 8'd2, 8, 32'hDEAD_BEEF);
    run_pkt(0, 1, 0, "R8", "R8");

    // R9: no end flag within length
    std_list(); adrs[7] = 8'h17;
    assemble(8'h05, 8'd2, 8, 32'h1);
    run_pkt(0, 0, 0, "R9", "R9");

    // R9: zero length
    assemble(8'h0D, 8'd0, 0, 32'h2);
    run_pkt(0, 0, 0, "R9", "R9");

    // R5: early end, trailing write-like pairs drained
    for (int i = 0; i < 8; i++) begin vals[i] = 8'(8'h40 + i); adrs[i] = 8'(8'h10 + i); end
    adrs[1] = 8'h91;
    assemble(8'h0F, 8'd2, 8, 32'h0BAD_F00D);
    run_pkt(0, 1, 0, "R5", "R7");

    // R11: go pulsed during a packet
    std_list();
    assemble(8'h09, 8'd2, 8, 32'h0);
    run_pkt(0, 0, 1, "R11", "R11");

    // random packets
    for (int p = 0; p < 40; p++) begin
      int len = 1 + int'($urandom % 6);
      int np = len * 4;
      int endp = int'($urandom % np);
      logic [7:0] ctrl = {4'h0, 1'($urandom), 1'($urandom), 1'b0, ($urandom % 10) != 0};
      for (int i = 0; i < np; i++) begin
        vals[i] = 8'($urandom);
        adrs[i] = 8'($urandom) & 8'h7F;
      end
      if (($urandom % 8) != 0) adrs[endp][7] = 1'b1;
      assemble(ctrl, 8'(len), np, $urandom);
      run_pkt(1'($urandom), 2, 0, "R3", "R7");
    end

    finish_run();
  end
endmodule